// File: doc/BRIEF.md
# Change-Notifying Pin Expander

This block is a register-mapped expander for up to sixteen general-purpose pins. Software programs a direction mask that says which pins are driven and a level word that says what they drive. A pin's effective output is its level bit gated by its direction bit. Board logic such as indicator lamps or supply switches does not poll the block. Instead, every register write that can move the effective output is followed by a comparison against the last recorded output. Each pin whose output moved gets a one-cycle strobe, and a companion vector carries the new recorded output.

External logic can force single level bits through a side port that gives a pin index and a value. Such an update changes the stored level and is visible on read-back, but it raises no event by itself. Any resulting change in the effective output is reported at the next direction or level write. Eight further word registers below the pin registers act as plain read/write storage. Reads are registered and return data one cycle after the request.

Event sequencing is done by a two-state controller. `ST_IDLE` waits for work. An accepted direction or level write moves it to `ST_NOTIFY` (transition *arm*). In `ST_NOTIFY` the output difference is latched into the strobe vector and the recorded output is refreshed. The controller then goes back to `ST_IDLE` (transition *settle*). If another pin write arrives in that same cycle, it stays in `ST_NOTIFY` (transition *rearm*).

Top module: `gpio_expander`

## Requirements
- R1: After reset the direction mask, the level word, the storage registers, the recorded output, `evt_strobe`, `evt_level` and `bus_rdata` are all zero.
- R2: A write to offset 0x24 stores `bus_wdata` ANDed with the current direction mask. Reading offset 0x28 (or 0x24) returns the stored level word.
- R3: A write to offset 0x20 sets the direction mask, which reads back at 0x20. A direction write leaves the stored level word unchanged.
- R4: After a level write sampled at clock edge E0, `evt_strobe` is high for exactly the cycle that follows edge E0+1. Its set bits are those where (level AND direction) differs from the recorded output. From that same edge, `evt_level` shows the new effective output.
- R5: A direction write produces events in the same way as a level write. Clearing a direction bit of a pin that drives 1 reports that pin with level 0.
- R6: A pin write that leaves the effective output unchanged produces an all-zero strobe, and `evt_level` keeps its value.
- R7: A side-port update (`ext_req`, `ext_pin`, `ext_val`) sets or clears one level bit whatever its direction. It raises no event by itself. A change it causes in the effective output is reported at the next pin write.
- R8: A side-port update whose `ext_pin` is 16 or more has no effect.
- R9: When a level write and a side-port update fall in the same cycle, the write is applied first and the side-port bit then overrides its one bit.
- R10: Offsets 0x00 to 0x1C, word aligned, are plain storage that reads back what was written. Reads of any other offset return zero, and writes to them (including 0x28) change nothing.
- R11: Pin writes in consecutive cycles each produce their own event cycle, in order, with no gap.
- R12: `bus_rdata` is updated only by a read request and holds its value until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ext_req | input | 1 | Side-port level update request |
| ext_pin | input | 5 | Pin index of the update |
| ext_val | input | 1 | New value of that level bit |
| evt_strobe | output | 16 | One-cycle per-pin change pulses |
| evt_level | output | 16 | Recorded effective output |

## Verification
Two functions can act on the level word in the same cycle: a bus level write and a side-port update. The bench provokes this by driving both in one cycle, with the side-port pin's direction bit set and the written word clearing it. It then judges the outcome from the read-back value and from the event cycle. The event must show both the bits cleared by the write and the side-port bit that survived. A second overlap puts a new pin write in the notify cycle of the previous one. The bench checks that the two strobe cycles come back to back and each carries its own difference.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int ADDR_W   = 8;
    localparam int NUM_AUX  = 8;
    localparam int AUX_W    = $clog2(NUM_AUX);

    localparam logic [ADDR_W-1:0] OFF_DIR    = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_LVL_WR = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_LVL_RD = 8'h28;
    localparam logic [ADDR_W-1:0] AUX_LIMIT  = ADDR_W'(NUM_AUX * 4);

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_NOTIFY = 1'b1
    } notify_state_t;

    typedef struct packed {
        logic dir_wr;
        logic lvl_wr;
        logic rd;
    } pin_access_t;

endpackage

// File: rtl/gpx_bus_decode.sv
module gpx_bus_decode
    import gpx_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] lvl_q,
    output pin_access_t         acc,
    output logic [NUM_PINS-1:0] bus_rdata
);

    logic                aligned;
    logic                is_aux;
    logic [AUX_W-1:0]    aux_idx;
    logic [NUM_PINS-1:0] aux_q [NUM_AUX];
    logic [NUM_PINS-1:0] rd_mux;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign is_aux  = aligned && (bus_addr < AUX_LIMIT);
    assign aux_idx = bus_addr[2 +: AUX_W];

    always_comb begin
        acc.dir_wr = bus_sel && bus_wr && (bus_addr == OFF_DIR);
        acc.lvl_wr = bus_sel && bus_wr && (bus_addr == OFF_LVL_WR);
        acc.rd     = bus_sel && !bus_wr;
    end

    for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                aux_q[g] <= '0;
            end else if (bus_sel && bus_wr && is_aux && (aux_idx == AUX_W'(g))) begin
                aux_q[g] <= bus_wdata;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (is_aux) begin
            rd_mux = aux_q[aux_idx];
        end else if (bus_addr == OFF_DIR) begin
            rd_mux = dir_q;
        end else if ((bus_addr == OFF_LVL_WR) || (bus_addr == OFF_LVL_RD)) begin
            rd_mux = lvl_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (acc.rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/gpx_pin_state.sv
module gpx_pin_state
    import gpx_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pin_access_t         acc,
    input  logic [NUM_PINS-1:0] bus_wdata,
    input  logic                ext_req,
    input  logic [IDX_W-1:0]    ext_pin,
    input  logic                ext_val,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] lvl_q
);

    localparam int PIN_W = $clog2(NUM_PINS);

    logic                ext_ok;
    logic [NUM_PINS-1:0] lvl_d;

    assign ext_ok = ext_req && (int'(ext_pin) < NUM_PINS);

    // Bus write first, then the side-port bit on top of it.
    always_comb begin
        lvl_d = lvl_q;
        if (acc.lvl_wr) begin
            lvl_d = bus_wdata & dir_q;
        end
        if (ext_ok) begin
            lvl_d[ext_pin[PIN_W-1:0]] = ext_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
            if (acc.dir_wr) begin
                dir_q <= bus_wdata;
            end
        end
    end

endmodule

// File: rtl/gpx_notify_fsm.sv
module gpx_notify_fsm
    import gpx_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin_wr,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] lvl_q,
    output logic [NUM_PINS-1:0] evt_strobe,
    output logic [NUM_PINS-1:0] evt_level
);

    notify_state_t       state_q;
    notify_state_t       state_d;
    logic [NUM_PINS-1:0] eff_out;
    logic [NUM_PINS-1:0] prev_q;

    assign eff_out = lvl_q & dir_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pin_wr) state_d = ST_NOTIFY;
            ST_NOTIFY: state_d = pin_wr ? ST_NOTIFY : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_strobe <= '0;
            prev_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    evt_strobe <= '0;
                end
                ST_NOTIFY: begin
                    evt_strobe <= eff_out ^ prev_q;
                    prev_q     <= eff_out;
                end
                default: begin
                    evt_strobe <= '0;
                end
            endcase
        end
    end

    assign evt_level = prev_q;

endmodule

// File: rtl/gpio_expander.sv
module gpio_expander
    import gpx_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic                ext_req,
    input  logic [IDX_W-1:0]    ext_pin,
    input  logic                ext_val,
    output logic [NUM_PINS-1:0] evt_strobe,
    output logic [NUM_PINS-1:0] evt_level
);

    pin_access_t         acc;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] lvl_q;

    gpx_bus_decode #(.NUM_PINS(NUM_PINS)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dir_q     (dir_q),
        .lvl_q     (lvl_q),
        .acc       (acc),
        .bus_rdata (bus_rdata)
    );

    gpx_pin_state #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .bus_wdata (bus_wdata),
        .ext_req   (ext_req),
        .ext_pin   (ext_pin),
        .ext_val   (ext_val),
        .dir_q     (dir_q),
        .lvl_q     (lvl_q)
    );

    gpx_notify_fsm #(.NUM_PINS(NUM_PINS)) u_notify (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_wr     (acc.dir_wr || acc.lvl_wr),
        .dir_q      (dir_q),
        .lvl_q      (lvl_q),
        .evt_strobe (evt_strobe),
        .evt_level  (evt_level)
    );

endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
    import gpx_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int IDX_W    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic                ext_req,
    input logic [IDX_W-1:0]    ext_pin,
    input logic [NUM_PINS-1:0] evt_strobe,
    input logic [NUM_PINS-1:0] evt_level,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] lvl_q
);

    logic pin_hit;
    logic lvl_hit;
    assign lvl_hit = bus_sel && bus_wr && (bus_addr == OFF_LVL_WR);
    assign pin_hit = lvl_hit || (bus_sel && bus_wr && (bus_addr == OFF_DIR));

    // R4
    strobe_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_strobe) |-> ((evt_level ^ $past(evt_level)) == evt_strobe));

    // R6
    quiet_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|evt_strobe) |-> $stable(evt_level));

    // R4
    strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_strobe) |-> $past(pin_hit, 2));

    // R2
    level_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_hit && !ext_req) |=> (lvl_q == ($past(bus_wdata) & dir_q)));

    // R8
    range_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && (int'(ext_pin) >= NUM_PINS) && !lvl_hit) |=> $stable(lvl_q));

endmodule

bind gpio_expander gpx_checker #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_gpx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ext_req    (ext_req),
    .ext_pin    (ext_pin),
    .evt_strobe (evt_strobe),
    .evt_level  (evt_level),
    .dir_q      (dir_q),
    .lvl_q      (lvl_q)
);

// File: tb/test_gpio_expander.sv
module test_gpio_expander;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_req = 1'b0;
    logic [4:0]  ext_pin = '0;
    logic        ext_val = 1'b0;
    logic [15:0] evt_strobe;
    logic [15:0] evt_level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_expander i_gpio_expander (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ext_req    (ext_req),
        .ext_pin    (ext_pin),
        .ext_val    (ext_val),
        .evt_strobe (evt_strobe),
        .evt_level  (evt_level)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic side_set(input logic [4:0] p, input logic v);
        @(negedge clk);
        ext_req = 1'b1; ext_pin = p; ext_val = v;
        @(negedge clk);
        ext_req = 1'b0;
    endtask

    task automatic expect_event(input string tag, input logic [15:0] s, input logic [15:0] l);
        @(negedge clk);
        chk({tag, " strobe"}, evt_strobe, s);
        chk({tag, " level"}, evt_level, l);
        @(negedge clk);
        chk({tag, " strobe clears"}, evt_strobe, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] r;
        chk("R1 rdata", bus_rdata, 16'h0000);
        chk("R1 strobe", evt_strobe, 16'h0000);
        chk("R1 level", evt_level, 16'h0000);
        bus_read(8'h20, r); chk("R1 dir", r, 16'h0000);
        bus_read(8'h28, r); chk("R1 lvl", r, 16'h0000);
        bus_read(8'h0C, r); chk("R1 storage", r, 16'h0000);
    endtask

    task automatic t_level_write();
        logic [15:0] r;
        bus_write(8'h20, 16'h00FF);
        expect_event("R6 dir with zero level", 16'h0000, 16'h0000);
        bus_write(8'h24, 16'h0F0F);
        expect_event("R4 level write", 16'h000F, 16'h000F);
        bus_read(8'h28, r); chk("R2 masked store", r, 16'h000F);
        bus_read(8'h24, r); chk("R2 alias read", r, 16'h000F);
    endtask

    task automatic t_dir_write();
        logic [15:0] r;
        bus_write(8'h20, 16'h00F3);
        expect_event("R5 dir clears pins", 16'h000C, 16'h0003);
        bus_read(8'h28, r); chk("R3 level untouched", r, 16'h000F);
        bus_read(8'h20, r); chk("R3 dir readback", r, 16'h00F3);
    endtask

    task automatic t_no_change();
        bus_write(8'h24, 16'hFF03);
        expect_event("R6 unchanged output", 16'h0000, 16'h0003);
    endtask

    task automatic t_side_port();
        logic [15:0] r;
        side_set(5'd7, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7 no event from side port", evt_strobe, 16'h0000);
        end
        bus_read(8'h28, r); chk("R7 side set visible", r, 16'h0083);
        bus_write(8'h20, 16'h00F3);
        expect_event("R7 deferred event", 16'h0080, 16'h0083);
        side_set(5'd12, 1'b1);
        side_set(5'd0, 1'b0);
        bus_read(8'h28, r); chk("R7 set and clear", r, 16'h1082);
    endtask

    task automatic t_range();
        logic [15:0] r;
        side_set(5'd16, 1'b1);
        side_set(5'd31, 1'b1);
        bus_read(8'h28, r); chk("R8 out of range ignored", r, 16'h1082);
        chk("R8 no event", evt_strobe, 16'h0000);
    endtask

    task automatic t_same_cycle();
        logic [15:0] r;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h24; bus_wdata = 16'h0000;
        ext_req = 1'b1; ext_pin = 5'd1; ext_val = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ext_req = 1'b0;
        expect_event("R9 write plus side port", 16'h0081, 16'h0002);
        bus_read(8'h28, r); chk("R9 side bit wins", r, 16'h0002);
    endtask

    task automatic t_back_to_back();
        logic [15:0] r;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h24; bus_wdata = 16'h00F0;
        @(negedge clk);
        bus_addr = 8'h20; bus_wdata = 16'h000F;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        chk("R11 first strobe", evt_strobe, 16'h00F2);
        chk("R11 first level", evt_level, 16'h00F0);
        expect_event("R11 second", 16'h00F0, 16'h0000);
        bus_read(8'h28, r); chk("R3 level after dir", r, 16'h00F0);
    endtask

    task automatic t_storage();
        logic [15:0] r;
        for (int i = 0; i < 8; i++) begin
            bus_write(8'(i * 4), 16'hA500 ^ 16'(i * 16'h0111));
        end
        for (int i = 0; i < 8; i++) begin
            bus_read(8'(i * 4), r);
            chk("R10 storage readback", r, 16'hA500 ^ 16'(i * 16'h0111));
        end
        bus_write(8'h2C, 16'h1234);
        bus_read(8'h2C, r); chk("R10 unmapped reads zero", r, 16'h0000);
        bus_read(8'h06, r); chk("R10 misaligned reads zero", r, 16'h0000);
        bus_write(8'h28, 16'hFFFF);
        @(negedge clk);
        chk("R10 read-only offset no event", evt_strobe, 16'h0000);
        bus_read(8'h28, r); chk("R10 read-only offset ignored", r, 16'h00F0);
        @(negedge clk);
        @(negedge clk);
        chk("R12 rdata holds", bus_rdata, 16'h00F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level_write();
        t_dir_write();
        t_no_change();
        t_side_port();
        t_range();
        t_same_cycle();
        t_back_to_back();
        t_storage();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

endmodule